// File: doc/BRIEF.md
# Text-Mode VGA Character Display

This block produces a 640x480 VGA raster and draws a monochrome grid of 40 by 16 character cells in it. A character RAM keeps a 6-bit code for each cell. A glyph ROM turns a code and a glyph line into an 8-dot pattern. Each dot is drawn as a 2x2 block of screen pixels, so one cell covers 16x16 pixels. The text grid fills the top 256 scan lines. Everything below that, and everything outside the visible area, is black.

A host loads the RAM through a write port that selects a cell by row and column. A write is qualified by a slower write clock: the strobe has effect only while that clock is low. This gives the row, column and code inputs time to settle before the write.

The RAM and ROM reads take two cycles and the pixel output is registered. The sync outputs are delayed by the same three stages, so every pixel leaves the block in the same cycle as the sync state for its position.

Top module: `txt_vga_display`

## Requirements
- R1: While rst_ni is low, pix_o is 0 and hsync_o and vsync_o are both 1.
- R2: Each line is H_ACT+H_FP+H_SYNC+H_BP pixels long. hsync_o is low for H_SYNC pixels starting at pixel H_ACT+H_FP and high otherwise. The defaults are 640/16/96/48.
- R3: Each frame is V_ACT+V_FP+V_SYNC+V_BP lines long. vsync_o is low for V_SYNC lines starting at line V_ACT+V_FP. The defaults are 480/10/2/33.
- R4: Screen pixel (x,y) with y below 256 and x below 640 shows the character at RAM address {row[3:0], col[5:0]}, where row = y/16 and col = x/16. The glyph line is (y mod 16)/2 and the dot is (x mod 16)/2. Glyph bit 7 is the leftmost dot, and a 1 dot is drawn as pix_o = 1.
- R5: Code 01 (octal) uses the glyph lines 00011000, 00111100, 01100110, 01111110, 01100110, 01100110, 01100110, 00000000 from top to bottom. Code 040 (octal) is blank.
- R6: Codes 072 to 077 (octal) show the same glyphs as codes 01 to 06. Any other code without its own glyph shows a box: lines 0 and 7 are 00000000, lines 1 and 6 are 01111110, and lines 2 to 5 are 01000010.
- R7: pix_o is 0 outside the visible area and on every scan line from 256 onwards, even though those lines map back onto RAM rows.
- R8: A write stores wr_code_i at the clock edge only when wr_req_i is 1 and wr_clk_i is 0. With wr_clk_i at 1, the cell keeps its old code.
- R9: A write with wr_row_i of 16 or more is discarded. It must not alias onto row wr_row_i[3:0].
- R10: After the last line of a frame, the raster restarts at pixel (0,0) and the pixels repeat frame after frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_clk_i | input | 1 | Slow write clock; a write is allowed only while it is low |
| wr_req_i | input | 1 | Write request |
| wr_row_i | input | 6 | Target text row, 0 to 15 |
| wr_col_i | input | 6 | Target text column, 0 to 39 |
| wr_code_i | input | 6 | Character code to store |
| pix_o | output | 1 | Monochrome pixel, 1 is white |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
The bench places the same glyph in several cells and samples individual pixels at the edges of lit dots. A wrong bit order, a missing 2x2 doubling or an off-by-one in the pipeline delay would move the lit region by one or two pixels. It checks the hsync edges at their exact pixel positions, so sync that was not delayed along with the pixel path would fall three pixels early. Line 256 is sampled where row 0 has a lit dot: a design that does not blank below the text area would repeat the top row there. The bench also tries a write to row 16 and a write while the slow clock is high, and then reads back the cells those writes could have corrupted. A last sample in the second frame shows whether the counters wrap correctly.

// File: rtl/txt_vga_pkg.sv
package txt_vga_pkg;
  localparam int CODE_W  = 6;
  localparam int IDX_W   = 6;
  localparam int CELL_SH = 4;   // 16x16 pixel cell
  localparam int DOT_W   = 3;

  typedef struct packed {
    logic             hs_n;
    logic             vs_n;
    logic             txt;
    logic [DOT_W-1:0] dot;
  } pipe_t;

  localparam pipe_t PIPE_RST = '{hs_n: 1'b1, vs_n: 1'b1, txt: 1'b0, dot: '0};

  function automatic logic [7:0] glyph_bits(input logic [CODE_W-1:0] code,
                                            input logic [DOT_W-1:0] ln);
    logic [CODE_W-1:0] c;
    logic [7:0]        r;
    c = (code >= 6'o72) ? code - 6'o71 : code;   // hex alias to A..F
    if (c == 6'o40) begin
      r = 8'h00;
    end else if (c == 6'o01) begin
      case (ln)
        3'd0:    r = 8'b0001_1000;
        3'd1:    r = 8'b0011_1100;
        3'd3:    r = 8'b0111_1110;
        3'd7:    r = 8'b0000_0000;
        default: r = 8'b0110_0110;
      endcase
    end else begin
      case (ln)
        3'd0, 3'd7: r = 8'h00;
        3'd1, 3'd6: r = 8'h7E;
        default:    r = 8'h42;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/txt_vga_timing.sv
module txt_vga_timing #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [H_W-1:0] h_o,
  output logic [V_W-1:0] v_o,
  output logic           hs_n_o,
  output logic           vs_n_o,
  output logic           de_o
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);
  localparam logic [H_W-1:0] HS_BEG = H_W'(H_ACT + H_FP);
  localparam logic [H_W-1:0] HS_END = H_W'(H_ACT + H_FP + H_SYNC);
  localparam logic [V_W-1:0] VS_BEG = V_W'(V_ACT + V_FP);
  localparam logic [V_W-1:0] VS_END = V_W'(V_ACT + V_FP + V_SYNC);

  logic [H_W-1:0] h_q;
  logic [V_W-1:0] v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_o    = h_q;
  assign v_o    = v_q;
  assign hs_n_o = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign vs_n_o = !((v_q >= VS_BEG) && (v_q < VS_END));
  assign de_o   = (h_q < H_W'(H_ACT)) && (v_q < V_W'(V_ACT));
endmodule

// File: rtl/txt_vga_cram.sv
module txt_vga_cram #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 6,
  parameter int DATA_W = 6,
  localparam int A_W   = ROW_W + COL_W,
  localparam int DEPTH = 1 << A_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [A_W-1:0]    waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [A_W-1:0]    raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/txt_vga_glyph_rom.sv
module txt_vga_glyph_rom
  import txt_vga_pkg::*;
(
  input  logic              clk_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DOT_W-1:0]  line_i,
  output logic [7:0]        bits_o
);
  always_ff @(posedge clk_i) bits_o <= glyph_bits(code_i, line_i);
endmodule

// File: rtl/txt_vga_display.sv
module txt_vga_display
  import txt_vga_pkg::*;
#(
  parameter int H_ACT    = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACT    = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int TXT_ROWS = 16,
  parameter int TXT_COLS = 40,
  localparam int H_TOTAL   = H_ACT + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL   = V_ACT + V_FP + V_SYNC + V_BP,
  localparam int H_W       = $clog2(H_TOTAL),
  localparam int V_W       = $clog2(V_TOTAL),
  localparam int ROW_W     = $clog2(TXT_ROWS),
  localparam int COL_W     = IDX_W,
  localparam int TXT_LINES = TXT_ROWS << CELL_SH,
  localparam int TXT_PX    = TXT_COLS << CELL_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_clk_i,
  input  logic              wr_req_i,
  input  logic [IDX_W-1:0]  wr_row_i,
  input  logic [IDX_W-1:0]  wr_col_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic              pix_o,
  output logic              hsync_o,
  output logic              vsync_o
);
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  logic           hs_n0, vs_n0, de0, txt0;

  txt_vga_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tim (
    .clk_i, .rst_ni,
    .h_o(h_cnt), .v_o(v_cnt), .hs_n_o(hs_n0), .vs_n_o(vs_n0), .de_o(de0)
  );

  assign txt0 = de0 && (v_cnt < V_W'(TXT_LINES)) && (h_cnt < H_W'(TXT_PX));

  // write qualification: slow clock low, row inside the grid
  logic wr_en;
  assign wr_en = wr_req_i && !wr_clk_i && (wr_row_i < IDX_W'(TXT_ROWS));

  logic [ROW_W+COL_W-1:0] rd_addr, wr_addr;
  logic [CODE_W-1:0]      code_s1;
  assign rd_addr = {v_cnt[CELL_SH +: ROW_W], h_cnt[CELL_SH +: COL_W]};
  assign wr_addr = {wr_row_i[ROW_W-1:0], wr_col_i};

  txt_vga_cram #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(CODE_W)) u_cram (
    .clk_i, .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_code_i),
    .raddr_i(rd_addr), .rdata_o(code_s1)
  );

  // side pipeline keeps sync and dot select aligned with the fetches
  pipe_t             p1_q, p2_q;
  logic [DOT_W-1:0]  line_s1;
  logic [7:0]        bits_s2;
  logic              txt_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q    <= PIPE_RST;
      p2_q    <= PIPE_RST;
      line_s1 <= '0;
    end else begin
      p1_q    <= '{hs_n: hs_n0, vs_n: vs_n0, txt: txt0, dot: h_cnt[1 +: DOT_W]};
      line_s1 <= v_cnt[1 +: DOT_W];
      p2_q    <= p1_q;
    end
  end
  assign txt_s1 = p1_q.txt;

  txt_vga_glyph_rom u_rom (
    .clk_i, .code_i(code_s1), .line_i(line_s1), .bits_o(bits_s2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else begin
      pix_o   <= p2_q.txt && bits_s2[3'd7 - p2_q.dot];
      hsync_o <= p2_q.hs_n;
      vsync_o <= p2_q.vs_n;
    end
  end
endmodule

module txt_vga_display_chk #(
  parameter int H_TOT     = 800,
  parameter int V_W       = 10,
  parameter int TXT_LINES = 256,
  parameter int ROWS      = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pix_o,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           wr_en_i,
  input logic           wr_clk_i,
  input logic [5:0]     wr_row_i,
  input logic           txt_s1_i,
  input logic [V_W-1:0] v_i
);
  assert_hblank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !pix_o);
  assert_vblank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> !pix_o);
  assert_hsync_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |=> !hsync_o);
  assert_text_band_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txt_s1_i |-> ($past(v_i) < V_W'(TXT_LINES)));
  assert_wr_phase_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !wr_clk_i);
  assert_wr_row_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_row_i < 6'(ROWS)));

  int   cnt;
  logic hs_d, seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= 0;
      hs_d <= 1'b1;
      seen <= 1'b0;
    end else begin
      hs_d <= hsync_o;
      if (hs_d && !hsync_o) begin
        assert_hsync_period_R2: assert (!seen || cnt == H_TOT)
          else $error("hsync period %0d", cnt);
        seen <= 1'b1;
        cnt  <= 1;
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

bind txt_vga_display txt_vga_display_chk #(
  .H_TOT(H_TOTAL), .V_W(V_W), .TXT_LINES(TXT_LINES), .ROWS(TXT_ROWS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pix_o(pix_o), .hsync_o(hsync_o),
  .vsync_o(vsync_o), .wr_en_i(wr_en), .wr_clk_i(wr_clk_i),
  .wr_row_i(wr_row_i), .txt_s1_i(txt_s1), .v_i(v_cnt)
);

// File: tb/txt_vga_display_test.sv
module txt_vga_display_test;
  localparam int HT = 656;   // 640+4+8+4
  localparam int VT = 264;   // 260+1+2+1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_clk = 1'b1, wr_req = 1'b0;
  logic [5:0] wr_row = '0, wr_col = '0, wr_code = '0;
  logic pix, hs, vs;

  int n_chk = 0, n_bad = 0, e = 0;
  bit done = 0;

  always #2 clk = ~clk;

  txt_vga_display #(
    .H_ACT(640), .H_FP(4), .H_SYNC(8), .H_BP(4),
    .V_ACT(260), .V_FP(1), .V_SYNC(2), .V_BP(1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_clk_i(wr_clk), .wr_req_i(wr_req),
    .wr_row_i(wr_row), .wr_col_i(wr_col), .wr_code_i(wr_code),
    .pix_o(pix), .hsync_o(hs), .vsync_o(vs)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) e <= 0; else e <= e + 1;

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // move to the cycle where pixel (x,y) of frame f is on the outputs
  task automatic goto_px(input int x, input int y, input int f = 0);
    int p = f * HT * VT + y * HT + x + 3;
    while (e < p) @(negedge clk);
    if (e != p) cmp("sched", "pixel order", e, p);
  endtask

  task automatic px(input string req, input int x, input int y, input int exp, input int f = 0);
    goto_px(x, y, f);
    cmp(req, $sformatf("pix(%0d,%0d)", x, y), int'(pix), exp);
  endtask

  task automatic wr(input int row, input int col, input int code, input bit slow_hi);
    @(negedge clk);
    wr_row = 6'(row); wr_col = 6'(col); wr_code = 6'(code);
    wr_clk = slow_hi; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; wr_clk = 1'b1;
  endtask

  task automatic t_reset;
    cmp("R1", "pix in reset", int'(pix), 0);
    cmp("R1", "hsync in reset", int'(hs), 1);
    cmp("R1", "vsync in reset", int'(vs), 1);
  endtask

  task automatic t_glyph_a;   // cell (0,0) = 01
    px("R5", 5, 0, 0); px("R5", 6, 0, 1); px("R4", 9, 0, 1); px("R4", 10, 0, 0);
    px("R4", 6, 1, 1);
    px("R4", 1, 6, 0); px("R5", 2, 6, 1); px("R5", 13, 6, 1); px("R4", 14, 6, 0);
  endtask

  task automatic t_row_discard;  // cell (0,3) stays blank after row-16 write
    px("R9", 50, 7, 0);
  endtask

  task automatic t_hex_alias;    // cell (0,5) = 072
    px("R6", 81, 7, 0); px("R6", 82, 7, 1); px("R6", 93, 7, 1);
  endtask

  task automatic t_glyph_a_tail;
    px("R5", 6, 14, 0); px("R5", 6, 15, 0);
  endtask

  task automatic t_hsync;
    px("R7", 640, 20, 0);
    goto_px(643, 20); cmp("R2", "hsync x643", int'(hs), 1);
    goto_px(644, 20); cmp("R2", "hsync x644", int'(hs), 0);
    goto_px(651, 20); cmp("R2", "hsync x651", int'(hs), 0);
    goto_px(652, 20); cmp("R2", "hsync x652", int'(hs), 1);
  endtask

  task automatic t_space;        // cell (1,2) = 040
    px("R5", 34, 22, 0); px("R5", 40, 22, 0);
  endtask

  task automatic t_box_last_col; // cell (2,39) = 02
    px("R6", 630, 32, 0);
    px("R6", 625, 34, 0); px("R6", 626, 34, 1); px("R6", 637, 34, 1); px("R6", 638, 34, 0);
  endtask

  task automatic t_wr_gate;      // cell (3,0) keeps 040
    px("R8", 2, 54, 0);
  endtask

  task automatic t_last_row;     // cell (15,0) = 01
    px("R4", 1, 246, 0); px("R4", 2, 246, 1);
  endtask

  task automatic t_blank_rows;
    px("R7", 6, 256, 0); px("R7", 7, 257, 0);
  endtask

  task automatic t_vsync;
    goto_px(0, 260); cmp("R3", "vsync y260", int'(vs), 1);
    goto_px(0, 261); cmp("R3", "vsync y261", int'(vs), 0);
    goto_px(655, 262); cmp("R3", "vsync y262", int'(vs), 0);
    goto_px(0, 263); cmp("R3", "vsync y263", int'(vs), 1);
  endtask

  task automatic t_wrap;
    px("R10", 5, 0, 0, 1); px("R10", 6, 0, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    wr(0, 0, 'o01, 0);
    wr(0, 3, 'o40, 0);
    wr(16, 3, 'o01, 0);
    wr(0, 5, 'o72, 0);
    wr(1, 2, 'o40, 0);
    wr(2, 39, 'o02, 0);
    wr(3, 0, 'o40, 0);
    wr(3, 0, 'o01, 1);
    wr(15, 0, 'o01, 0);
    @(negedge clk);
    rst_n = 1'b1;
    t_glyph_a();
    t_row_discard();
    t_hex_alias();
    t_glyph_a_tail();
    t_hsync();
    t_space();
    t_box_last_col();
    t_wr_gate();
    t_last_row();
    t_blank_rows();
    t_vsync();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule